// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block funnels eight interrupt request lines into one interrupt output towards a host processor. Each line can latch on a rising edge or follow its level, and can be blocked by a mask bit. Requests that have been raised but not yet taken are held in a pending register. Requests that the host has taken but not yet finished are held in an in-service register. A request is offered to the host only when it outranks every level currently in service. Ranking is either fixed, or rotating so that the level most recently finished drops to the bottom.

The host takes a request by pulsing an acknowledge input. One cycle later the block returns an 8-bit vector. This vector is the programmed base in the upper five bits with the winning line number below it. If the request disappeared before the acknowledge, the block returns the line-7 vector as a spurious indication. The host finishes a request with a non-specific end-of-interrupt command written through a small synchronous register port. Alternatively, the block can run in automatic end-of-interrupt mode, where the acknowledge itself closes the request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, every line is edge-triggered, priority is fixed, automatic end-of-interrupt is off, the vector base is zero, and both intOut and vecValid are low.
- R2: An edge-triggered line sets its pending bit on a low-to-high transition. A line held high sets it only once; it must return low and rise again to request again.
- R3: A level-triggered line has its pending bit track the input on each clock. A line that drops before acknowledge leaves nothing pending.
- R4: A pending request whose mask bit is 1 never drives intOut. Clearing the mask bit lets the still-pending request through.
- R5: intOut is high exactly when some unmasked pending line ranks strictly above every in-service line. Equal or lower lines wait.
- R6: An acknowledge pulse in cycle N gives vecValid high in cycle N+1 only, with vecOut = {base[7:3], winning line[2:0]}. The acknowledge clears the winner's pending bit and sets its in-service bit.
- R7: An acknowledge with no eligible request returns {base, 3'b111} and changes no in-service bit.
- R8: In fixed priority, line 0 ranks highest and line 7 lowest.
- R9: The end-of-interrupt command clears only the highest-ranked in-service bit. Lower in-service levels keep blocking.
- R10: With automatic end-of-interrupt on, an acknowledge sets no in-service bit, so no command is needed before lower lines are offered.
- R11: In rotating priority, the level closed by an end-of-interrupt (command or automatic) becomes the lowest rank. The line after it becomes the highest. Before any rotation, line 7 is lowest.
- R12: The register port writes on cfgWrEn at each clock, decoded by cfgAddr: 0 sets level trigger per line (1 = level); 1 sets the mask (1 = blocked); 2 sets control (bit 0 rotate, bit 1 automatic end-of-interrupt); 3 sets the vector base from data bits 7:3; 4 issues a non-specific end-of-interrupt (data ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irqIn | input | 8 | Interrupt request lines, bit i is line i |
| cfgWrEn | input | 1 | Register port write strobe |
| cfgAddr | input | 3 | Register port address |
| cfgWrData | input | 8 | Register port write data |
| ackReq | input | 1 | One-cycle acknowledge from the host |
| intOut | output | 1 | Interrupt request to the host |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecOut | output | 8 | Returned vector |

## Verification
A stale pending bit, a lost in-service bit or a wrong rotation pointer shows up at the ports as intOut rising or falling in the wrong cycle. It can also show up as a different line number in the next returned vector. Comparing both outputs against a behavioural model on every clock therefore exposes a corrupted register within one cycle of the stimulus that depends on it. Directed sequences make nested service, spurious acknowledge, masking and rotation each depend on exactly one such bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N  = 8;
  localparam int LVL_W  = $clog2(IRQ_N);
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - LVL_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG = 3'd0,
    REG_MASK = 3'd1,
    REG_CTRL = 3'd2,
    REG_BASE = 3'd3,
    REG_EOI  = 3'd4
  } regSel_e;

  // strobes from the resolver to the register datapath
  typedef struct packed {
    logic             ackTake;
    logic [LVL_W-1:0] ackLvl;
    logic             eoiTake;
    logic [LVL_W-1:0] eoiLvl;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_state.sv
module irq_state
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irqIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [VEC_W-1:0]  cfgWrData,
  input  ctlStrobe_t        strb,
  output logic [IRQ_N-1:0]  pending,
  output logic [IRQ_N-1:0]  inService,
  output logic [IRQ_N-1:0]  maskBits,
  output logic              rotateEn,
  output logic              autoEoi,
  output logic [BASE_W-1:0] vecBase,
  output logic [LVL_W-1:0]  lowestLvl,
  output logic              eoiReq
);
  logic [IRQ_N-1:0] irqPrev;
  logic [IRQ_N-1:0] levelSel;

  assign eoiReq = cfgWrEn && (cfgAddr == REG_EOI);

  // configuration and edge history
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPrev  <= '0;
      levelSel <= '0;
      maskBits <= '0;
      rotateEn <= 1'b0;
      autoEoi  <= 1'b0;
      vecBase  <= '0;
    end else begin
      irqPrev <= irqIn;
      if (cfgWrEn) begin
        case (cfgAddr)
          REG_TRIG: levelSel <= cfgWrData[IRQ_N-1:0];
          REG_MASK: maskBits <= cfgWrData[IRQ_N-1:0];
          REG_CTRL: begin
            rotateEn <= cfgWrData[0];
            autoEoi  <= cfgWrData[1];
          end
          REG_BASE: vecBase <= cfgWrData[VEC_W-1:LVL_W];
          default: ;
        endcase
      end
    end
  end

  // rotation pointer: the level most recently closed ranks lowest
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowestLvl <= LVL_W'(IRQ_N - 1);
    end else if (rotateEn) begin
      if (strb.eoiTake)
        lowestLvl <= strb.eoiLvl;
      else if (strb.ackTake && autoEoi)
        lowestLvl <= strb.ackLvl;
    end
  end

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    logic pendQ, servQ, rise, ackHit, eoiHit;
    assign rise   = irqIn[g] & ~irqPrev[g];
    assign ackHit = strb.ackTake && (strb.ackLvl == LVL_W'(g));
    assign eoiHit = strb.eoiTake && (strb.eoiLvl == LVL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pendQ <= 1'b0;
        servQ <= 1'b0;
      end else begin
        if (ackHit)           pendQ <= 1'b0;
        else if (levelSel[g]) pendQ <= irqIn[g];
        else if (rise)        pendQ <= 1'b1;

        if (ackHit && !autoEoi) servQ <= 1'b1;
        else if (eoiHit)        servQ <= 1'b0;
      end
    end

    assign pending[g]   = pendQ;
    assign inService[g] = servQ;

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (levelSel[g] && !ackHit) |=> (pendQ == $past(irqIn[g]))); // R3
    AST_EDGE_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (!levelSel[g] && irqPrev[g] && irqIn[g] && !pendQ) |=> !pendQ); // R2
  end

  AST_AUTO_EOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackTake && autoEoi) |=> ($countones(inService & ~$past(inService)) == 0)); // R10
  AST_ONE_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(inService) & ~inService) <= 1); // R9
  AST_ONE_SERVICE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inService & ~$past(inService)) <= 1); // R6
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  pending,
  input  logic [IRQ_N-1:0]  inService,
  input  logic [IRQ_N-1:0]  maskBits,
  input  logic              rotateEn,
  input  logic [BASE_W-1:0] vecBase,
  input  logic [LVL_W-1:0]  lowestLvl,
  input  logic              eoiReq,
  input  logic              ackReq,
  output ctlStrobe_t        strb,
  output logic              intOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecOut
);
  logic             winFound, eoiFound;
  logic [LVL_W-1:0] winLvl, eoiLvl;

  // walk levels from highest rank down; an in-service level stops the search
  always_comb begin
    logic [LVL_W-1:0] topLvl;
    logic [LVL_W-1:0] lvl;
    logic             blocked;
    topLvl   = rotateEn ? LVL_W'(lowestLvl + 1'b1) : '0;
    winFound = 1'b0;
    eoiFound = 1'b0;
    blocked  = 1'b0;
    winLvl   = '0;
    eoiLvl   = '0;
    for (int k = 0; k < IRQ_N; k++) begin
      lvl = LVL_W'(topLvl + LVL_W'(k));
      if (!eoiFound && inService[lvl]) begin
        eoiFound = 1'b1;
        eoiLvl   = lvl;
      end
      if (!winFound && !blocked) begin
        if (inService[lvl]) begin
          blocked = 1'b1;
        end else if (pending[lvl] && !maskBits[lvl]) begin
          winFound = 1'b1;
          winLvl   = lvl;
        end
      end
    end
  end

  assign intOut       = winFound;
  assign strb.ackTake = ackReq && winFound;
  assign strb.ackLvl  = winLvl;
  assign strb.eoiTake = eoiReq && eoiFound;
  assign strb.eoiLvl  = eoiLvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= ackReq;
      if (ackReq)
        vecOut <= {vecBase, winFound ? winLvl : LVL_W'(IRQ_N - 1)};
    end
  end

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ackReq |=> vecValid); // R6
  AST_NO_STRAY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !ackReq |=> !vecValid); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((pending & ~maskBits) != '0)); // R4
  AST_SPURIOUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ackReq && !intOut) |=> (vecOut[LVL_W-1:0] == '1)); // R7
  AST_NOT_BEHIND_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((pending & ~maskBits & ~inService) != '0)); // R5
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irqIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [VEC_W-1:0]  cfgWrData,
  input  logic              ackReq,
  output logic              intOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecOut
);
  ctlStrobe_t        strb;
  logic [IRQ_N-1:0]  pending, inService, maskBits;
  logic              rotateEn, autoEoi, eoiReq;
  logic [BASE_W-1:0] vecBase;
  logic [LVL_W-1:0]  lowestLvl;

  irq_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqIn     (irqIn),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .strb      (strb),
    .pending   (pending),
    .inService (inService),
    .maskBits  (maskBits),
    .rotateEn  (rotateEn),
    .autoEoi   (autoEoi),
    .vecBase   (vecBase),
    .lowestLvl (lowestLvl),
    .eoiReq    (eoiReq)
  );

  irq_resolve u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (pending),
    .inService (inService),
    .maskBits  (maskBits),
    .rotateEn  (rotateEn),
    .vecBase   (vecBase),
    .lowestLvl (lowestLvl),
    .eoiReq    (eoiReq),
    .ackReq    (ackReq),
    .strb      (strb),
    .intOut    (intOut),
    .vecValid  (vecValid),
    .vecOut    (vecOut)
  );
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqIn = '0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       ackReq = 1'b0;
  logic       intOut, vecValid;
  logic [7:0] vecOut;

  int nChecks = 0;
  int nFail = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .ackReq(ackReq),
    .intOut(intOut), .vecValid(vecValid), .vecOut(vecOut)
  );

  // behavioural reference state
  logic [7:0] mPend, mIsr, mMask, mLevel, mPrev;
  logic       mRot, mAuto, mVecValid;
  logic [4:0] mBase;
  logic [7:0] mVec;
  int         mLow;

  function automatic void resolve(output int w, output int e);
    int top, l;
    bit blk;
    top = mRot ? (mLow + 1) % 8 : 0;
    w = -1; e = -1; blk = 0;
    for (int k = 0; k < 8; k++) begin
      l = (top + k) % 8;
      if (e < 0 && mIsr[l]) e = l;
      if (w < 0 && !blk) begin
        if (mIsr[l]) blk = 1;
        else if (mPend[l] && !mMask[l]) w = l;
      end
    end
  endfunction

  always @(posedge clk) begin
    int w, e;
    bit eoiNow;
    logic [7:0] nP, nI;
    if (!rst_n) begin
      mPend = '0; mIsr = '0; mMask = '0; mLevel = '0; mPrev = '0;
      mRot = 0; mAuto = 0; mBase = '0; mLow = 7; mVecValid = 0; mVec = '0;
    end else begin
      resolve(w, e);
      eoiNow = cfgWrEn && cfgAddr == 3'd4;
      nP = mPend; nI = mIsr;
      for (int i = 0; i < 8; i++) begin
        if (mLevel[i]) nP[i] = irqIn[i];
        else if (irqIn[i] && !mPrev[i]) nP[i] = 1'b1;
      end
      if (ackReq && w >= 0) begin
        nP[w] = 1'b0;
        if (!mAuto) nI[w] = 1'b1;
      end
      if (eoiNow && e >= 0) nI[e] = 1'b0;
      if (mRot) begin
        if (eoiNow && e >= 0) mLow = e;
        else if (ackReq && w >= 0 && mAuto) mLow = w;
      end
      mVecValid = ackReq;
      if (ackReq) mVec = {mBase, (w >= 0) ? 3'(w) : 3'd7};
      if (cfgWrEn) begin
        case (cfgAddr)
          3'd0: mLevel = cfgWrData;
          3'd1: mMask = cfgWrData;
          3'd2: begin mRot = cfgWrData[0]; mAuto = cfgWrData[1]; end
          3'd3: mBase = cfgWrData[7:3];
          default: ;
        endcase
      end
      mPend = nP; mIsr = nI; mPrev = irqIn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    int w, e;
    if (running && rst_n) begin
      resolve(w, e);
      check(intOut == (w >= 0), "R5 intOut vs model", intOut, (w >= 0));
      check(vecValid == mVecValid, "R6 vecValid vs model", vecValid, mVecValid);
      if (mVecValid) check(vecOut == mVec, "R6 vecOut vs model", vecOut, mVec);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d; tick(); cfgWrEn = 1'b0;
  endtask
  task automatic ackDo(); ackReq = 1'b1; tick(); ackReq = 1'b0; endtask
  task automatic setIrq(input int i, input logic v); irqIn[i] = v; tick(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    running = 1;
    tick();
    check(intOut == 0, "R1 reset intOut", intOut, 0);
    check(vecValid == 0, "R1 reset vecValid", vecValid, 0);
    ackDo();
    check(vecOut == 8'h07, "R1 R7 reset base spurious", vecOut, 8'h07);

    wr(3, 8'h40);
    setIrq(3, 1);
    check(intOut == 1, "R2 edge sets pending", intOut, 1);
    ackDo();
    check(vecOut == 8'h43, "R6 vector base and line", vecOut, 8'h43);
    check(intOut == 0, "R6 in-service blocks", intOut, 0);
    wr(4, 8'h00);
    check(intOut == 0, "R2 held line no retrigger", intOut, 0);
    setIrq(3, 0);

    irqIn[5] = 1; irqIn[2] = 1; tick();
    ackDo();
    check(vecOut == 8'h42, "R8 fixed line 2 over 5", vecOut, 8'h42);
    check(intOut == 0, "R5 lower waits", intOut, 0);
    wr(4, 8'h00);
    check(intOut == 1, "R9 eoi releases lower", intOut, 1);
    ackDo();
    check(vecOut == 8'h45, "R8 next line 5", vecOut, 8'h45);
    wr(4, 8'h00);
    irqIn = '0; tick();

    setIrq(6, 1);
    ackDo();
    setIrq(1, 1);
    check(intOut == 1, "R5 higher preempts", intOut, 1);
    ackDo();
    check(vecOut == 8'h41, "R5 nested vector", vecOut, 8'h41);
    setIrq(7, 1);
    wr(4, 8'h00);
    check(intOut == 0, "R9 line 6 still blocks 7", intOut, 0);
    wr(4, 8'h00);
    check(intOut == 1, "R9 second eoi frees 7", intOut, 1);
    ackDo();
    check(vecOut == 8'h47, "R9 line 7 vector", vecOut, 8'h47);
    wr(4, 8'h00);
    irqIn = '0; tick();

    wr(1, 8'h10);
    setIrq(4, 1);
    check(intOut == 0, "R4 masked no int", intOut, 0);
    ackDo();
    check(vecOut == 8'h47, "R7 spurious when masked", vecOut, 8'h47);
    wr(1, 8'h00);
    check(intOut == 1, "R4 unmask releases", intOut, 1);
    ackDo();
    check(vecOut == 8'h44, "R4 vector after unmask", vecOut, 8'h44);
    wr(4, 8'h00);
    irqIn = '0; tick();

    wr(0, 8'h01);
    setIrq(0, 1);
    check(intOut == 1, "R3 level high pending", intOut, 1);
    setIrq(0, 0);
    check(intOut == 0, "R3 level drop clears", intOut, 0);
    ackDo();
    check(vecOut == 8'h47, "R7 spurious after drop", vecOut, 8'h47);
    setIrq(7, 1);
    check(intOut == 1, "R7 spurious set no service", intOut, 1);
    ackDo();
    wr(4, 8'h00);
    setIrq(7, 0);
    setIrq(0, 1);
    ackDo();
    check(vecOut == 8'h40, "R3 level vector", vecOut, 8'h40);
    wr(4, 8'h00);
    check(intOut == 1, "R3 level still high re-pends", intOut, 1);
    setIrq(0, 0);
    wr(0, 8'h00);

    wr(2, 8'h02);
    setIrq(2, 1);
    ackDo();
    check(vecOut == 8'h42, "R10 auto vector", vecOut, 8'h42);
    setIrq(5, 1);
    check(intOut == 1, "R10 no service bit left", intOut, 1);
    ackDo();
    check(vecOut == 8'h45, "R10 lower served", vecOut, 8'h45);
    irqIn = '0; tick();

    wr(2, 8'h01);
    setIrq(3, 1);
    ackDo();
    check(vecOut == 8'h43, "R11 rotate start", vecOut, 8'h43);
    wr(4, 8'h00);
    setIrq(3, 0);
    irqIn[2] = 1; irqIn[4] = 1; tick();
    ackDo();
    check(vecOut == 8'h44, "R11 line 4 now above 2", vecOut, 8'h44);
    wr(4, 8'h00);
    ackDo();
    check(vecOut == 8'h42, "R11 then line 2", vecOut, 8'h42);
    wr(4, 8'h00);
    irqIn = '0; tick();
    wr(2, 8'h00);

    // R12 random register traffic, all compared against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 16;
      if (r < 6) begin irqIn[$urandom % 8] ^= 1'b1; tick(); end
      else if (r < 8) ackDo();
      else if (r == 8) wr(4, 8'($urandom));
      else if (r == 9) wr(1, 8'($urandom) & 8'($urandom));
      else if (r == 10) wr(0, 8'($urandom));
      else if (r == 11) wr(2, 8'($urandom % 4));
      else if (r == 12) wr(3, 8'($urandom));
      else tick();
    end

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule